// File: doc/BRIEF.md
# Morse Symbol Run-Length Classifier

This block watches a single-bit keying line in which a low level means a tone is present (a mark) and a high level means silence (a space). It counts the length in clock cycles of every run of marks and spaces. When a run is long enough to carry meaning, the block sorts it into one of four symbol kinds: a short mark (dot), a long mark (dash), a medium space between letters, or a long space between words. Each symbol appears as a one-cycle valid strobe together with exactly one symbol flag, and symbols leave in the order in which their runs happened.

The timing unit of the keying is not fixed. The block keeps a running estimate of the unit, between 2 and 4 cycles by default, and refreshes it from every mark it classifies. All decisions compare the measured run against multiples of that estimate. This gives each run a margin of up to one unit less one cycle around its nominal length. Short spaces inside a letter produce nothing, and silence before the first mark after a clear is ignored.

Top module: `morse_run_classifier`

## Requirements
- R1: The level on `key_n` is sampled on each rising clock edge, with 0 meaning mark and 1 meaning space. While `clr` is high, and after it falls, all outputs are 0. Until the first mark is sampled, no space of any length produces a strobe.
- R2: `sym_valid` is high for one cycle per symbol, and in that cycle exactly one of `sym_dot`, `sym_dash`, `sym_lgap`, `sym_wgap` is high. When `sym_valid` is low, all four flags are low. Each run yields at most one symbol, and symbols come out in run order.
- R3: A mark run of L cycles with L < 2u, where u is the current unit estimate, gives a dot strobe. The strobe is visible right after the edge that samples the first space cycle.
- R4: A mark run of L cycles with L >= 2u gives a dash strobe, with the same timing as R3.
- R5: A space run with 2u <= L, for which no word gap was raised, gives a letter-gap strobe right after the edge that samples the next mark. A space with L < 2u gives nothing.
- R6: A space raises a word-gap strobe right after the edge at which its length reaches 5u cycles. It raises it only once, however long the space lasts, and that space then gives no letter gap when it ends.
- R7: The unit estimate starts at 3 after a clear. A dot of length L sets it to L clamped to [2,4]. A dash of length L sets it to round(L/3) clamped to [2,4], with halves rounded up. The new value applies from the next run on.
- R8: The run counter saturates at 255 cycles and never wraps. A mark of more than 255 cycles is still one dash.
- R9: Raising `clr` clears the outputs and the learned state at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| clr | input | 1 | Asynchronous active-high clear to the idle state |
| key_n | input | 1 | Keying line, 0 = mark, 1 = space |
| sym_dot | output | 1 | Dot flag, meaningful with `sym_valid` |
| sym_dash | output | 1 | Dash flag, meaningful with `sym_valid` |
| sym_lgap | output | 1 | Letter-gap flag, meaningful with `sym_valid` |
| sym_wgap | output | 1 | Word-gap flag, meaningful with `sym_valid` |
| sym_valid | output | 1 | One-cycle symbol strobe |

## Verification
The block is driven with several kinds of keying. Exact three-cycle-unit keying of a short phrase checks the basic sorting into all four symbols. Keying with jitter at units of 2 and 4 checks that every run still falls on the correct side of the 2u and 5u thresholds. A sequence of marks of lengths 2, 4, 3, 5 and 7 shows that the dot/dash boundary follows the learned unit: a 4-cycle mark counts as a dash, while later 5- and 7-cycle marks count as dots. Runs of 300 cycles reach counter saturation and show a single word-gap strobe with no letter gap after it, and a clear raised between clock edges shows that outputs drop without a clock.

// File: rtl/morse_pkg.sv
package morse_pkg;

  // Index of each symbol flag in the internal flag vector.
  typedef enum int {
    SYM_DOT  = 0,
    SYM_DASH = 1,
    SYM_LGAP = 2,
    SYM_WGAP = 3
  } sym_e;

  localparam int SYM_COUNT = 4;

  // Rounded division by three: the largest k with 2*len >= 6*k - 3.
  function automatic int round_third(input int len);
    return (2 * len + 3) / 6;
  endfunction

endpackage

// File: rtl/morse_run_tracker.sv
module morse_run_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             mark_i,
  output logic             active_o,
  output logic [CNT_W-1:0] len_o,
  output logic [CNT_W-1:0] len_inc_o,
  output logic             same_o,
  output logic             mark_end_o,
  output logic             space_end_o
);

  localparam logic [CNT_W-1:0] LEN_MAX = '1;
  localparam logic [CNT_W-1:0] LEN_ONE = CNT_W'(1);

  logic             active_q;
  logic             level_q;
  logic [CNT_W-1:0] len_q;

  always_comb begin
    len_inc_o   = (len_q == LEN_MAX) ? LEN_MAX : len_q + LEN_ONE;
    same_o      = active_q & (mark_i == level_q);
    mark_end_o  = active_q & level_q & ~mark_i;
    space_end_o = active_q & ~level_q & mark_i;
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      active_q <= 1'b0;
      level_q  <= 1'b0;
      len_q    <= '0;
    end else if (!active_q) begin
      if (mark_i) begin
        active_q <= 1'b1;
        level_q  <= 1'b1;
        len_q    <= LEN_ONE;
      end
    end else if (mark_i == level_q) begin
      len_q <= len_inc_o;
    end else begin
      level_q <= mark_i;
      len_q   <= LEN_ONE;
    end
  end

  assign active_o = active_q;
  assign len_o    = len_q;

  // R8: once running, a run always has a non-zero length
  assert_run_nonzero_R8: assert property (@(posedge clk) disable iff (clr)
    active_q |-> (len_q != '0));

  // R8: a full counter holds its value while the run continues
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (clr)
    (same_o && len_q == LEN_MAX) |=> (len_q == LEN_MAX));

endmodule

// File: rtl/morse_unit_tracker.sv
module morse_unit_tracker #(
  parameter int UNIT_MIN  = 2,
  parameter int UNIT_MAX  = 4,
  parameter int UNIT_INIT = 3,
  parameter int CNT_W     = 8,
  parameter int U_W       = $clog2(UNIT_MAX + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             dot_upd_i,
  input  logic             dash_upd_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [U_W-1:0]   unit_o
);

  logic [U_W-1:0] unit_q;
  logic [U_W-1:0] dot_est;
  logic [U_W-1:0] dash_est;

  always_comb begin
    if (int'(len_i) <= UNIT_MIN)      dot_est = U_W'(UNIT_MIN);
    else if (int'(len_i) >= UNIT_MAX) dot_est = U_W'(UNIT_MAX);
    else                              dot_est = U_W'(len_i);
  end

  always_comb begin
    dash_est = U_W'(UNIT_MIN);
    for (int k = UNIT_MIN + 1; k <= UNIT_MAX; k++) begin
      if (morse_pkg::round_third(int'(len_i)) >= k) dash_est = U_W'(k);
    end
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr)             unit_q <= U_W'(UNIT_INIT);
    else if (dot_upd_i)  unit_q <= dot_est;
    else if (dash_upd_i) unit_q <= dash_est;
  end

  assign unit_o = unit_q;

  // R7: the estimate never leaves its allowed range
  assert_unit_range_R7: assert property (@(posedge clk) disable iff (clr)
    (int'(unit_q) >= UNIT_MIN) && (int'(unit_q) <= UNIT_MAX));

  // R7: the estimate only moves when a mark is classified
  assert_unit_hold_R7: assert property (@(posedge clk) disable iff (clr)
    (!dot_upd_i && !dash_upd_i) |=> $stable(unit_q));

endmodule

// File: rtl/morse_symbol_judge.sv
module morse_symbol_judge #(
  parameter int CNT_W = 8,
  parameter int U_W   = 3
) (
  input  logic                           clk,
  input  logic                           clr,
  input  logic                           mark_i,
  input  logic                           same_i,
  input  logic                           mark_end_i,
  input  logic                           space_end_i,
  input  logic [CNT_W-1:0]               len_i,
  input  logic [CNT_W-1:0]               len_inc_i,
  input  logic [U_W-1:0]                 unit_i,
  output logic                           dot_upd_o,
  output logic                           dash_upd_o,
  output logic [morse_pkg::SYM_COUNT-1:0] flags_o,
  output logic                           valid_o
);
  import morse_pkg::*;

  logic                 wg_q;
  logic [SYM_COUNT-1:0] flags_q;
  logic                 valid_q;
  logic [SYM_COUNT-1:0] hit;
  logic                 is_short;
  int                   th_two;
  int                   th_five;

  always_comb begin
    th_two   = 2 * int'(unit_i);
    th_five  = 5 * int'(unit_i);
    is_short = int'(len_i) < th_two;
    dot_upd_o  = mark_end_i & is_short;
    dash_upd_o = mark_end_i & ~is_short;
    hit           = '0;
    hit[SYM_DOT]  = dot_upd_o;
    hit[SYM_DASH] = dash_upd_o;
    hit[SYM_LGAP] = space_end_i & ~wg_q & ~is_short;
    hit[SYM_WGAP] = same_i & ~mark_i & ~wg_q & (int'(len_inc_i) >= th_five);
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      wg_q    <= 1'b0;
      flags_q <= '0;
      valid_q <= 1'b0;
    end else begin
      flags_q <= hit;
      valid_q <= |hit;
      if (hit[SYM_WGAP])                 wg_q <= 1'b1;
      else if (mark_end_i | space_end_i) wg_q <= 1'b0;
    end
  end

  assign flags_o = flags_q;
  assign valid_o = valid_q;

  // R2: a strobe carries exactly one flag
  assert_onehot_R2: assert property (@(posedge clk) disable iff (clr)
    valid_q |-> ($countones(flags_q) == 1));

  // R2: no flag without a strobe
  assert_quiet_R2: assert property (@(posedge clk) disable iff (clr)
    !valid_q |-> (flags_q == '0));

  // R6: a word gap is never raised on two cycles in a row
  assert_wg_once_R6: assert property (@(posedge clk) disable iff (clr)
    flags_q[SYM_WGAP] |=> !flags_q[SYM_WGAP]);

  // R6: a space that already raised a word gap gives no letter gap
  assert_no_lgap_after_wg_R6: assert property (@(posedge clk) disable iff (clr)
    (wg_q && space_end_i) |=> !flags_q[SYM_LGAP]);

endmodule

// File: rtl/morse_run_classifier.sv
module morse_run_classifier #(
  parameter int UNIT_MIN  = 2,
  parameter int UNIT_MAX  = 4,
  parameter int UNIT_INIT = 3,
  parameter int CNT_W     = 8
) (
  input  logic clk,
  input  logic clr,
  input  logic key_n,
  output logic sym_dot,
  output logic sym_dash,
  output logic sym_lgap,
  output logic sym_wgap,
  output logic sym_valid
);
  import morse_pkg::*;

  localparam int U_W = $clog2(UNIT_MAX + 1);

  logic                 mark;
  logic                 active;
  logic [CNT_W-1:0]     run_len;
  logic [CNT_W-1:0]     run_len_inc;
  logic                 run_same;
  logic                 mark_end;
  logic                 space_end;
  logic                 dot_upd;
  logic                 dash_upd;
  logic [U_W-1:0]       unit;
  logic [SYM_COUNT-1:0] flags;

  assign mark = ~key_n;

  morse_run_tracker #(.CNT_W(CNT_W)) u_run (
    .clk         (clk),
    .clr         (clr),
    .mark_i      (mark),
    .active_o    (active),
    .len_o       (run_len),
    .len_inc_o   (run_len_inc),
    .same_o      (run_same),
    .mark_end_o  (mark_end),
    .space_end_o (space_end)
  );

  morse_unit_tracker #(
    .UNIT_MIN  (UNIT_MIN),
    .UNIT_MAX  (UNIT_MAX),
    .UNIT_INIT (UNIT_INIT),
    .CNT_W     (CNT_W),
    .U_W       (U_W)
  ) u_unit (
    .clk        (clk),
    .clr        (clr),
    .dot_upd_i  (dot_upd),
    .dash_upd_i (dash_upd),
    .len_i      (run_len),
    .unit_o     (unit)
  );

  morse_symbol_judge #(.CNT_W(CNT_W), .U_W(U_W)) u_judge (
    .clk         (clk),
    .clr         (clr),
    .mark_i      (mark),
    .same_i      (run_same),
    .mark_end_i  (mark_end),
    .space_end_i (space_end),
    .len_i       (run_len),
    .len_inc_i   (run_len_inc),
    .unit_i      (unit),
    .dot_upd_o   (dot_upd),
    .dash_upd_o  (dash_upd),
    .flags_o     (flags),
    .valid_o     (sym_valid)
  );

  assign sym_dot  = flags[SYM_DOT];
  assign sym_dash = flags[SYM_DASH];
  assign sym_lgap = flags[SYM_LGAP];
  assign sym_wgap = flags[SYM_WGAP];

  // R1: no symbol while still waiting for the first mark
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (clr)
    !active |-> !sym_valid);

endmodule

// File: tb/tb_morse_run_classifier.sv
`timescale 1ns/1ps
module tb_morse_run_classifier;

  logic clk = 1'b0;
  logic clr;
  logic key_n;
  logic sym_dot, sym_dash, sym_lgap, sym_wgap, sym_valid;

  int checks = 0;
  int fails  = 0;
  int c_dot = 0, c_dash = 0, c_lg = 0, c_wg = 0, c_val = 0;

  always #5 clk = ~clk;

  morse_run_classifier dut (
    .clk(clk), .clr(clr), .key_n(key_n),
    .sym_dot(sym_dot), .sym_dash(sym_dash), .sym_lgap(sym_lgap),
    .sym_wgap(sym_wgap), .sym_valid(sym_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int   m_idle, m_prev, m_len, m_wg, m_u;
  logic e_dot, e_dash, e_lg, e_wg;

  function automatic int clampu(input int v);
    return (v < 2) ? 2 : ((v > 4) ? 4 : v);
  endfunction

  always @(posedge clk or posedge clr) begin
    if (clr) begin
      m_idle = 1; m_prev = 0; m_len = 0; m_wg = 0; m_u = 3;
      e_dot = 0; e_dash = 0; e_lg = 0; e_wg = 0;
    end else begin
      int m;
      m = (key_n == 1'b0) ? 1 : 0;
      e_dot = 0; e_dash = 0; e_lg = 0; e_wg = 0;
      if (m_idle != 0) begin
        if (m != 0) begin m_idle = 0; m_prev = 1; m_len = 1; m_wg = 0; end
      end else if (m == m_prev) begin
        m_len = (m_len >= 255) ? 255 : m_len + 1;
        if (m == 0 && m_wg == 0 && m_len >= 5 * m_u) begin e_wg = 1; m_wg = 1; end
      end else if (m_prev != 0) begin
        if (m_len < 2 * m_u) begin e_dot = 1; m_u = clampu(m_len); end
        else begin e_dash = 1; m_u = clampu((2 * m_len + 3) / 6); end
        m_prev = 0; m_len = 1; m_wg = 0;
      end else begin
        if (m_wg == 0 && m_len >= 2 * m_u) e_lg = 1;
        m_prev = 1; m_len = 1; m_wg = 0;
      end
    end
  end

  // Compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (!clr) begin
      string tag;
      tag = e_dot ? "R3 dot" : e_dash ? "R4 dash" : e_lg ? "R5 letter gap" :
            e_wg ? "R6 word gap" : "R2 no symbol";
      chk(tag, int'({sym_valid, sym_wgap, sym_lgap, sym_dash, sym_dot}),
          int'({(e_dot | e_dash | e_lg | e_wg), e_wg, e_lg, e_dash, e_dot}));
      c_dot  += int'(sym_dot);
      c_dash += int'(sym_dash);
      c_lg   += int'(sym_lgap);
      c_wg   += int'(sym_wgap);
      c_val  += int'(sym_valid);
    end
  end

  task automatic run(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      key_n = lvl;
      @(negedge clk); #1;
    end
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk); #1;
    clr = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  int b_dot, b_dash, b_lg, b_wg, b_val;
  task automatic snap();
    b_dot = c_dot; b_dash = c_dash; b_lg = c_lg; b_wg = c_wg; b_val = c_val;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    clr = 1'b1; key_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", int'({sym_valid, sym_wgap, sym_lgap, sym_dash, sym_dot}), 0);
    #1 clr = 1'b0;

    // R1: long silence before any mark
    snap();
    run(1'b1, 40);
    chk("R1 silence at start", c_val - b_val, 0);

    // Exact keying, unit 3: dot dash | dot || dot
    snap();
    run(1'b0, 3); run(1'b1, 3); run(1'b0, 9); run(1'b1, 9);
    run(1'b0, 3); run(1'b1, 21); run(1'b0, 3); run(1'b1, 2);
    chk("R3 dot count", c_dot - b_dot, 3);
    chk("R4 dash count", c_dash - b_dash, 1);
    chk("R5 letter gap count", c_lg - b_lg, 1);
    chk("R6 word gap count", c_wg - b_wg, 1);
    chk("R2 one strobe per symbol", c_val - b_val, 6);

    // R7: threshold follows the learned unit
    do_clear();
    snap();
    run(1'b0, 2); run(1'b1, 1); run(1'b0, 4); run(1'b1, 3);
    run(1'b0, 3); run(1'b1, 1); run(1'b0, 5); run(1'b1, 1);
    run(1'b0, 7); run(1'b1, 9); run(1'b0, 1); run(1'b1, 3);
    chk("R7 dots with moving unit", c_dot - b_dot, 5);
    chk("R7 dash with unit 2", c_dash - b_dash, 1);
    chk("R7 letter gap at unit 4", c_lg - b_lg, 1);
    chk("R7 no word gap", c_wg - b_wg, 0);

    // Jittered keying at unit 4 and unit 2
    do_clear();
    run(1'b0, 5); run(1'b1, 3); run(1'b0, 14); run(1'b1, 13);
    run(1'b0, 4); run(1'b1, 30); run(1'b0, 12); run(1'b1, 2);
    run(1'b0, 1); run(1'b1, 2); run(1'b0, 7); run(1'b1, 5);
    run(1'b0, 3); run(1'b1, 13); run(1'b0, 2); run(1'b1, 4);

    // R8 saturation and R6 single word gap on a very long space
    do_clear();
    snap();
    run(1'b0, 300); run(1'b1, 300); run(1'b0, 2); run(1'b1, 2);
    chk("R8 long mark is one dash", c_dash - b_dash, 1);
    chk("R6 one word gap for long space", c_wg - b_wg, 1);
    chk("R6 no letter gap after word gap", c_lg - b_lg, 0);
    chk("R8 dot after saturation", c_dot - b_dot, 1);

    // R9: asynchronous clear between edges
    do_clear();
    run(1'b0, 3);
    key_n = 1'b1;
    @(posedge clk); #2;
    chk("R3 dot strobe before clear", int'(sym_valid & sym_dot), 1);
    clr = 1'b1;
    #1;
    chk("R9 outputs drop without clock",
        int'({sym_valid, sym_wgap, sym_lgap, sym_dash, sym_dot}), 0);
    @(negedge clk); #1;
    clr = 1'b0;
    snap();
    run(1'b1, 30);
    chk("R9 cleared block is idle", c_val - b_val, 0);

    summary();
    $finish;
  end

endmodule